// File: doc/BRIEF.md
# DMA Transfer Mode Selector

This block picks the fastest DMA transfer mode that both the host controller and the attached device can handle, without going above a mode requested by the caller. It takes the device capability words, the host capability masks, a cable-detect flag, the media type and the requested mode code. It returns one 8-bit mode code, or zero when no DMA mode can be used.

Three families of modes are searched in a fixed order: ultra (codes from 0x40), multiword (codes from 0x20) and single-word (codes from 0x10). The first family that gives a nonzero host/device intersection wins. Within that family the highest common mode is chosen. A missing 80-wire cable caps the ultra family at mode 2. A device that reports no single-word mask can still be given single-word modes through its legacy timing mode number. The caller strobes `req_valid` with stable inputs and reads the result one clock later.

Top module: `dms_mode_pick`

## Requirements
- R1: While `rst_n` is low, and on the first edge after its release, `out_valid` is 0 and `out_mode` is 0x00.
- R2: `out_valid` goes high exactly one clock after a cycle with `req_valid` high, and is low otherwise. `out_mode` changes only on the clock that follows a `req_valid` cycle, and otherwise keeps its value.
- R3: The families are tried in priority order ultra (base 0x40), multiword (base 0x20), single-word (base 0x10). A family whose base is above `req_mode` is skipped. The first family whose mask is nonzero decides the result.
- R4: Inside the winning family, the chosen code is the family base plus the index of the highest set bit of that family's mask.
- R5: The ultra family takes part only when `dev_valid[2]` is 1. Its mask is `host_ultra & dev_ultra[6:0]`, with bit n standing for ultra mode n.
- R6: When `req_mode` is above 0x42, the ultra mask has any of bits 6:3 set and `cable80` is 0, the ultra mask is cut down to bits 2:0.
- R7: The multiword family takes part only when `dev_valid[1]` is 1. Its mask is `host_mw & dev_mword[2:0]`.
- R8: The single-word mask is `dev_sword[2:0] & host_sw` when `dev_valid[1]` is 1. Otherwise, a `dev_legacy` value m of at most 2 gives the mask `((2<<m)-1) & host_sw`, and a larger m gives an empty mask.
- R9: The output is the smaller of the chosen code and `req_mode`. It is 0x00 when no family gives a mode.
- R10: When `is_disk` is 0 and `atapi_ok` is 0, the output is 0x00 whatever the capabilities are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Strobe: evaluate the present inputs |
| req_mode | input | 8 | Highest mode code the caller accepts |
| dev_valid | input | 3 | Device field-valid bits (bit 1: word masks valid, bit 2: ultra word valid) |
| dev_ultra | input | 16 | Device ultra capability word |
| dev_mword | input | 16 | Device multiword capability word |
| dev_sword | input | 16 | Device single-word capability word |
| dev_legacy | input | 8 | Device legacy single-word timing mode number |
| host_ultra | input | 7 | Host ultra mode mask |
| host_mw | input | 3 | Host multiword mode mask |
| host_sw | input | 3 | Host single-word mode mask |
| cable80 | input | 1 | 80-wire cable detected |
| is_disk | input | 1 | Device is a disk |
| atapi_ok | input | 1 | DMA allowed for non-disk devices |
| out_valid | output | 1 | Result valid, one clock after the strobe |
| out_mode | output | 8 | Selected mode code, 0x00 when none |

## Verification
Directed patterns set one family at a time so that each can win. They include full ultra support with and without the cable, a requested mode just above and at ultra mode 2, a requested mode inside the multiword range while ultra is also available, empty host masks, and legacy timing numbers on both sides of the limit of 2. These separate an error in the family order from an error in the cable cut, in the clamp or in the legacy path. Random vectors with idle gaps then cover mixed masks and check that the result holds while no strobe is given. Non-disk devices are tried with ATAPI DMA both allowed and refused.

// File: rtl/dms_pkg.sv
`timescale 1ns/1ps
package dms_pkg;
  localparam int MODE_W = 8;
  localparam int NUM_FAM = 3;
  localparam logic [MODE_W-1:0] ULTRA_BASE = 8'h40;
  localparam logic [MODE_W-1:0] MWORD_BASE = 8'h20;
  localparam logic [MODE_W-1:0] SWORD_BASE = 8'h10;
  localparam int VB_DMA   = 1;
  localparam int VB_ULTRA = 2;
  localparam int ULTRA_CABLE_TOP = 2;
  localparam int SW_LEGACY_MAX = 2;

  // family index 0 has the highest priority
  function automatic logic [MODE_W-1:0] fam_base(input int f);
    case (f)
      0:       fam_base = ULTRA_BASE;
      1:       fam_base = MWORD_BASE;
      default: fam_base = SWORD_BASE;
    endcase
  endfunction
endpackage

// File: rtl/dms_msb_index.sv
`timescale 1ns/1ps
module dms_msb_index #(
  parameter int W = 7,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     mask,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (mask[i]) idx = IDX_W'(i);
    end
    found = |mask;
  end
endmodule

// File: rtl/dms_family_masks.sv
`timescale 1ns/1ps
module dms_family_masks
  import dms_pkg::*;
#(
  parameter int ULTRA_W = 7,
  parameter int MW_W    = 3,
  parameter int SW_W    = 3,
  parameter int WORD_W  = 16,
  parameter int LEG_W   = 8
) (
  input  logic [MODE_W-1:0]  req_mode,
  input  logic [2:0]         dev_valid,
  input  logic [WORD_W-1:0]  dev_ultra,
  input  logic [WORD_W-1:0]  dev_mword,
  input  logic [WORD_W-1:0]  dev_sword,
  input  logic [LEG_W-1:0]   dev_legacy,
  input  logic [ULTRA_W-1:0] host_ultra,
  input  logic [MW_W-1:0]    host_mw,
  input  logic [SW_W-1:0]    host_sw,
  input  logic               cable80,
  output logic [ULTRA_W-1:0] ultra_mask,
  output logic [MW_W-1:0]    mw_mask,
  output logic [SW_W-1:0]    sw_mask
);
  localparam int KEEP_BITS = ULTRA_CABLE_TOP + 1;
  localparam logic [ULTRA_W-1:0] KEEP_MASK = ULTRA_W'((1 << KEEP_BITS) - 1);
  localparam logic [MODE_W-1:0] CABLE_LIMIT = ULTRA_BASE + MODE_W'(ULTRA_CABLE_TOP);

  logic [ULTRA_W-1:0] ultra_raw;
  logic               cable_cut;
  logic [SW_W-1:0]    leg_mask;
  logic               leg_ok;

  always_comb begin
    ultra_raw = host_ultra & dev_ultra[ULTRA_W-1:0];
    cable_cut = (req_mode > CABLE_LIMIT) && (|(ultra_raw & ~KEEP_MASK)) && !cable80;
    if (dev_valid[VB_ULTRA] && (req_mode >= ULTRA_BASE))
      ultra_mask = cable_cut ? (ultra_raw & KEEP_MASK) : ultra_raw;
    else
      ultra_mask = '0;
  end

  always_comb begin
    if (dev_valid[VB_DMA] && (req_mode >= MWORD_BASE))
      mw_mask = host_mw & dev_mword[MW_W-1:0];
    else
      mw_mask = '0;
  end

  // legacy timing number m enables single-word modes 0..m
  always_comb begin
    leg_ok = dev_legacy <= LEG_W'(SW_LEGACY_MAX);
    for (int i = 0; i < SW_W; i++) begin
      leg_mask[i] = LEG_W'(i) <= dev_legacy;
    end
    if (req_mode < SWORD_BASE)
      sw_mask = '0;
    else if (dev_valid[VB_DMA])
      sw_mask = dev_sword[SW_W-1:0] & host_sw;
    else if (leg_ok)
      sw_mask = leg_mask & host_sw;
    else
      sw_mask = '0;
  end
endmodule

// File: rtl/dms_mode_pick.sv
`timescale 1ns/1ps
module dms_mode_pick
  import dms_pkg::*;
#(
  parameter int ULTRA_W = 7,
  parameter int MW_W    = 3,
  parameter int SW_W    = 3,
  parameter int WORD_W  = 16,
  parameter int LEG_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [MODE_W-1:0]  req_mode,
  input  logic [2:0]         dev_valid,
  input  logic [WORD_W-1:0]  dev_ultra,
  input  logic [WORD_W-1:0]  dev_mword,
  input  logic [WORD_W-1:0]  dev_sword,
  input  logic [LEG_W-1:0]   dev_legacy,
  input  logic [ULTRA_W-1:0] host_ultra,
  input  logic [MW_W-1:0]    host_mw,
  input  logic [SW_W-1:0]    host_sw,
  input  logic               cable80,
  input  logic               is_disk,
  input  logic               atapi_ok,
  output logic               out_valid,
  output logic [MODE_W-1:0]  out_mode
);
  localparam int FAM_W0 = (ULTRA_W > MW_W) ? ULTRA_W : MW_W;
  localparam int FAM_W  = (FAM_W0 > SW_W) ? FAM_W0 : SW_W;
  localparam int IDX_W  = (FAM_W > 1) ? $clog2(FAM_W) : 1;

  logic [ULTRA_W-1:0] ultra_mask;
  logic [MW_W-1:0]    mw_mask;
  logic [SW_W-1:0]    sw_mask;
  logic [NUM_FAM-1:0][FAM_W-1:0] fam_mask;
  logic [NUM_FAM-1:0]            fam_found;
  logic [NUM_FAM-1:0][IDX_W-1:0] fam_idx;
  logic [MODE_W-1:0] sel_mode, clamp_mode, pick_mode;
  logic [MODE_W-1:0] mode_d, mode_q;
  logic              valid_d, valid_q;

  dms_family_masks #(
    .ULTRA_W(ULTRA_W), .MW_W(MW_W), .SW_W(SW_W), .WORD_W(WORD_W), .LEG_W(LEG_W)
  ) masks_i (
    .req_mode(req_mode), .dev_valid(dev_valid), .dev_ultra(dev_ultra),
    .dev_mword(dev_mword), .dev_sword(dev_sword), .dev_legacy(dev_legacy),
    .host_ultra(host_ultra), .host_mw(host_mw), .host_sw(host_sw),
    .cable80(cable80), .ultra_mask(ultra_mask), .mw_mask(mw_mask), .sw_mask(sw_mask)
  );

  assign fam_mask[0] = FAM_W'(ultra_mask);
  assign fam_mask[1] = FAM_W'(mw_mask);
  assign fam_mask[2] = FAM_W'(sw_mask);

  for (genvar g = 0; g < NUM_FAM; g++) begin : g_fam
    dms_msb_index #(.W(FAM_W), .IDX_W(IDX_W)) enc_i (
      .mask(fam_mask[g]), .found(fam_found[g]), .idx(fam_idx[g])
    );
  end

  // lowest priority first so the highest-priority hit overrides
  always_comb begin
    sel_mode = '0;
    for (int f = NUM_FAM - 1; f >= 0; f--) begin
      if (fam_found[f]) sel_mode = fam_base(f) + MODE_W'(fam_idx[f]);
    end
    clamp_mode = (sel_mode < req_mode) ? sel_mode : req_mode;
    pick_mode  = (!is_disk && !atapi_ok) ? '0 : clamp_mode;
  end

  always_comb begin
    valid_d = req_valid;
    mode_d  = req_valid ? pick_mode : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mode_q  <= '0;
    end else begin
      valid_q <= valid_d;
      mode_q  <= mode_d;
    end
  end

  assign out_valid = valid_q;
  assign out_mode  = mode_q;
endmodule

// File: rtl/dms_mode_pick_chk.sv
`timescale 1ns/1ps
module dms_mode_pick_chk
  import dms_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [MODE_W-1:0] req_mode,
  input logic [2:0]        dev_valid,
  input logic              cable80,
  input logic              is_disk,
  input logic              atapi_ok,
  input logic              out_valid,
  input logic [MODE_W-1:0] out_mode
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
  assert_mode_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(out_mode));
  assert_family_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode < SWORD_BASE) |=> out_mode == '0);
  assert_ultra_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !dev_valid[VB_ULTRA]) |=> out_mode < ULTRA_BASE);
  assert_cable_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cable80) |=> out_mode <= ULTRA_BASE + MODE_W'(ULTRA_CABLE_TOP));
  assert_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_mode <= $past(req_mode));
  assert_atapi_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !is_disk && !atapi_ok) |=> out_mode == '0);
endmodule

bind dms_mode_pick dms_mode_pick_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
  .dev_valid(dev_valid), .cable80(cable80), .is_disk(is_disk), .atapi_ok(atapi_ok),
  .out_valid(out_valid), .out_mode(out_mode)
);

// File: tb/dms_mode_pick_tb.sv
`timescale 1ns/1ps
module dms_mode_pick_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [7:0]  req_mode;
  logic [2:0]  dev_valid;
  logic [15:0] dev_ultra, dev_mword, dev_sword;
  logic [7:0]  dev_legacy;
  logic [6:0]  host_ultra;
  logic [2:0]  host_mw, host_sw;
  logic        cable80, is_disk, atapi_ok;
  logic        out_valid;
  logic [7:0]  out_mode;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  string cur_tag = "R1";
  string exp_tag = "R1";
  logic       exp_valid;
  logic [7:0] exp_mode;

  always #4 clk = ~clk;

  dms_mode_pick dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .dev_valid(dev_valid), .dev_ultra(dev_ultra), .dev_mword(dev_mword),
    .dev_sword(dev_sword), .dev_legacy(dev_legacy), .host_ultra(host_ultra),
    .host_mw(host_mw), .host_sw(host_sw), .cable80(cable80), .is_disk(is_disk),
    .atapi_ok(atapi_ok), .out_valid(out_valid), .out_mode(out_mode)
  );

  function automatic int top_bit(input int m);
    int r = -1;
    for (int i = 0; i < 16; i++) if (m[i]) r = i;
    return r;
  endfunction

  // behavioural reference written from the requirements
  function automatic logic [7:0] ref_pick();
    int mask;
    int pick = 0;
    if (!is_disk && !atapi_ok) return 8'h00;                       // R10
    if (req_mode >= 8'h40 && dev_valid[2]) begin                   // R5
      mask = int'(host_ultra & dev_ultra[6:0]);
      if (req_mode > 8'h42 && (mask & 'h78) != 0 && !cable80) mask = mask & 7; // R6
      if (mask != 0) pick = 'h40 + top_bit(mask);                  // R4
    end
    if (pick == 0 && req_mode >= 8'h20 && dev_valid[1]) begin      // R7
      mask = int'(host_mw & dev_mword[2:0]);
      if (mask != 0) pick = 'h20 + top_bit(mask);
    end
    if (pick == 0 && req_mode >= 8'h10) begin                      // R8
      if (dev_valid[1]) mask = int'(dev_sword[2:0] & host_sw);
      else if (dev_legacy <= 2) mask = ((2 << dev_legacy) - 1) & int'(host_sw);
      else mask = 0;
      if (mask != 0) pick = 'h10 + top_bit(mask);
    end
    return (pick < int'(req_mode)) ? 8'(pick) : req_mode;          // R9
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid <= 1'b0;
      exp_mode  <= 8'h00;
      exp_tag   <= "R1";
    end else begin
      exp_valid <= req_valid;
      if (req_valid) begin
        exp_mode <= ref_pick();
        exp_tag  <= cur_tag;
      end else begin
        exp_tag  <= "R2";
      end
    end
  end

  task automatic compare();
    n_cmp++;
    if (out_valid !== exp_valid || out_mode !== exp_mode) begin
      n_bad++;
      $display("FAIL %s: valid=%0b mode=0x%02h, expected valid=%0b mode=0x%02h",
               exp_tag, out_valid, out_mode, exp_valid, exp_mode);
    end
  endtask

  always @(negedge clk) if (!done) compare();

  task automatic vec(input string tag, input logic [7:0] rq, input logic [2:0] dv,
                     input logic [15:0] du, input logic [15:0] dm, input logic [15:0] ds,
                     input logic [7:0] lg, input logic [6:0] hu, input logic [2:0] hm,
                     input logic [2:0] hs, input logic cab, input logic dsk, input logic at);
    @(negedge clk);
    #1;
    cur_tag = tag; req_valid = 1'b1; req_mode = rq; dev_valid = dv;
    dev_ultra = du; dev_mword = dm; dev_sword = ds; dev_legacy = lg;
    host_ultra = hu; host_mw = hm; host_sw = hs; cable80 = cab;
    is_disk = dsk; atapi_ok = at;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
      req_valid = 1'b0;
      req_mode  = 8'($urandom);           // ignored without strobe (R2)
      host_ultra = 7'($urandom);
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_mode = '0; dev_valid = '0;
    dev_ultra = '0; dev_mword = '0; dev_sword = '0; dev_legacy = '0;
    host_ultra = '0; host_mw = '0; host_sw = '0; cable80 = 1'b0;
    is_disk = 1'b1; atapi_ok = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;                          // R1 compared every cycle
    idle(2);
    // R4 R5: full ultra, cable present
    vec("R5", 8'h46, 3'b111, 16'h007F, 16'h0007, 16'h0007, 8'd0, 7'h7F, 3'h7, 3'h7, 1'b1, 1'b1, 1'b0);
    vec("R4", 8'hFF, 3'b111, 16'h0015, 16'h0007, 16'h0007, 8'd0, 7'h7F, 3'h7, 3'h7, 1'b1, 1'b1, 1'b0);
    // R6: no cable cuts to ultra 2
    vec("R6", 8'h46, 3'b111, 16'h007F, 16'h0007, 16'h0007, 8'd0, 7'h7F, 3'h7, 3'h7, 1'b0, 1'b1, 1'b0);
    vec("R6", 8'h43, 3'b111, 16'h0018, 16'h0007, 16'h0007, 8'd0, 7'h7F, 3'h7, 3'h7, 1'b0, 1'b1, 1'b0);
    vec("R6", 8'h42, 3'b111, 16'h007F, 16'h0007, 16'h0007, 8'd0, 7'h7F, 3'h7, 3'h7, 1'b0, 1'b1, 1'b0);
    // R9: clamp to request
    vec("R9", 8'h43, 3'b111, 16'h007F, 16'h0007, 16'h0007, 8'd0, 7'h7F, 3'h7, 3'h7, 1'b1, 1'b1, 1'b0);
    // R3: request in multiword range skips ultra
    vec("R3", 8'h21, 3'b111, 16'h007F, 16'h0007, 16'h0007, 8'd0, 7'h7F, 3'h7, 3'h7, 1'b1, 1'b1, 1'b0);
    vec("R3", 8'h0F, 3'b111, 16'h007F, 16'h0007, 16'h0007, 8'd0, 7'h7F, 3'h7, 3'h7, 1'b1, 1'b1, 1'b0);
    // R5 R7: no ultra valid bit, multiword wins
    vec("R7", 8'h46, 3'b011, 16'h007F, 16'h0003, 16'h0007, 8'd0, 7'h7F, 3'h7, 3'h7, 1'b1, 1'b1, 1'b0);
    vec("R3", 8'h46, 3'b111, 16'h007F, 16'h0007, 16'h0007, 8'd0, 7'h00, 3'h5, 3'h7, 1'b1, 1'b1, 1'b0);
    // R8: single-word paths
    vec("R8", 8'h46, 3'b111, 16'h0000, 16'h0000, 16'h0006, 8'd0, 7'h7F, 3'h7, 3'h3, 1'b1, 1'b1, 1'b0);
    vec("R8", 8'h46, 3'b000, 16'h007F, 16'h0007, 16'h0007, 8'd1, 7'h7F, 3'h7, 3'h7, 1'b1, 1'b1, 1'b0);
    vec("R8", 8'h46, 3'b000, 16'h007F, 16'h0007, 16'h0007, 8'd0, 7'h7F, 3'h7, 3'h7, 1'b1, 1'b1, 1'b0);
    vec("R8", 8'h46, 3'b000, 16'h007F, 16'h0007, 16'h0007, 8'd2, 7'h7F, 3'h7, 3'h3, 1'b1, 1'b1, 1'b0);
    vec("R8", 8'h46, 3'b000, 16'h007F, 16'h0007, 16'h0007, 8'd3, 7'h7F, 3'h7, 3'h7, 1'b1, 1'b1, 1'b0);
    // R10: non-disk devices
    vec("R10", 8'h46, 3'b111, 16'h007F, 16'h0007, 16'h0007, 8'd0, 7'h7F, 3'h7, 3'h7, 1'b1, 1'b0, 1'b0);
    vec("R10", 8'h46, 3'b111, 16'h007F, 16'h0007, 16'h0007, 8'd0, 7'h7F, 3'h7, 3'h7, 1'b1, 1'b0, 1'b1);
    idle(3);                               // R2 hold
    for (int n = 0; n < 400; n++) begin
      vec("R4", 8'($urandom_range(0, 80)), 3'($urandom), 16'($urandom), 16'($urandom),
          16'($urandom), 8'($urandom_range(0, 4)), 7'($urandom), 3'($urandom), 3'($urandom),
          1'($urandom), 1'($urandom_range(0, 3) != 0), 1'($urandom));
      if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
    end
    idle(2);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule